// File: doc/BRIEF.md
# Circuit Path Setup Controller (Source Side)

This block sits at the source end of a hybrid network. A packet-switched electrical network carries control traffic, and a separate photonic plane carries bulk data over circuits. When a client asks for a transfer, the controller sends a two-flit reserve packet into the electrical router, addressed to the destination. The reserve packet commits the switching points along the route. The controller then waits for the single grant pulse that the destination returns over the optical path. Once the grant arrives, it streams exactly the requested number of payload words onto the data channel. After the payload, it sends a two-flit release packet, and the circuit is torn down.

Only one circuit is handled at a time. A grant that does not arrive within a programmable window cancels the transfer: the release packet is still sent, no payload moves, and an error pulse replaces the done pulse. Grant pulses that arrive at any other moment change nothing except a saturating counter of stray grants.

Top module: `circuit_setup_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `req_ready` is 1. In the same cycles `flit_valid`, `ch_valid`, `pay_pop`, `done` and `error` are 0, and `stray_count` is 0.
- R2: When a request is accepted (`req_valid` and `req_ready` high at a clock edge), the controller emits a reserve head flit and then a reserve tail flit. Flit field layout: bits [15:14] carry the flit kind (01 = head, 10 = tail). Bits [13:12] carry the message type (00 = reserve, 01 = release). In a head flit, bits [5:0] carry the destination. Every other bit is 0.
- R3: While `flit_valid` is 1 and `flit_ready` is 0, `flit_valid` stays 1 and `flit_data` does not change.
- R4: After the reserve tail flit is accepted, a grant pulse is taken if it arrives in waiting cycle k, counted from 0, with k <= `timeout_cycles`. `ch_valid` stays 0 until that grant has been taken.
- R5: After the grant, exactly `req_len` words are sent, one in each cycle in which `ch_ready` is 1. In each such cycle `ch_data` equals `pay_word` and `pay_pop` is 1. A length of 0 sends no word.
- R6: After the last word, or right after a grant when the length is 0, the controller emits a release head flit carrying the same destination, followed by a release tail flit.
- R7: `done` is 1 for exactly one cycle, the cycle after the release tail flit is accepted, provided the grant was taken.
- R8: If no grant is taken by waiting cycle `timeout_cycles`, the release packet is sent with no payload. `error` then pulses for one cycle in place of `done`.
- R9: While a transfer is in progress, `req_ready` is 0, and a pending request does not alter the flits of the current transfer.
- R10: Each grant pulse outside the waiting phase increments `stray_count`. The counter saturates at its maximum value, and the stray pulse has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_dest | input | DEST_W | Destination address of the request |
| req_len | input | LEN_W | Number of payload words |
| timeout_cycles | input | TMO_W | Last waiting cycle in which a grant is still taken |
| flit_valid | output | 1 | Control flit offered to the electrical router |
| flit_ready | input | 1 | Router accepts the flit |
| flit_data | output | FLIT_W | Control flit contents |
| ack_pulse | input | 1 | Grant pulse from the optical side |
| ch_valid | output | 1 | Payload word offered on the data channel |
| ch_ready | input | 1 | Data channel takes the word |
| ch_data | output | DATA_W | Payload word on the data channel |
| pay_word | input | DATA_W | Next payload word from the client |
| pay_pop | output | 1 | Client word consumed this cycle |
| done | output | 1 | One-cycle pulse: transfer completed |
| error | output | 1 | One-cycle pulse: transfer cancelled by timeout |
| stray_count | output | STRAY_W | Saturating count of stray grant pulses |

## Verification
The checker assumes the following about the environment:
- The router and the data channel may drop ready at any cycle.
- A grant is a single-cycle pulse.
- `pay_word` holds the word that the client wants sent next.

The bench keeps to these assumptions. It raises each ready signal only on falling edges, and it throttles the data channel one cycle in three. It gives each grant pulse a lifetime of exactly one clock, placing it at chosen waiting cycles: the first cycle, the last permitted cycle, and one cycle late. Stray pulses are sent while the controller is idle, during payload transmission and during the release packet, so that the counter is exercised without any two pulses merging.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSV_HEAD,
        ST_RSV_TAIL,
        ST_WAIT_GRANT,
        ST_STREAM,
        ST_REL_HEAD,
        ST_REL_TAIL
    } csc_state_e;

    typedef enum logic [1:0] {
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10
    } flit_kind_e;

    typedef enum logic [1:0] {
        MSG_RESERVE = 2'b00,
        MSG_RELEASE = 2'b01
    } msg_type_e;

    function automatic logic offers_flit(csc_state_e s);
        return (s == ST_RSV_HEAD) || (s == ST_RSV_TAIL) ||
               (s == ST_REL_HEAD) || (s == ST_REL_TAIL);
    endfunction

    function automatic logic is_head_state(csc_state_e s);
        return (s == ST_RSV_HEAD) || (s == ST_REL_HEAD);
    endfunction

    function automatic logic is_release_state(csc_state_e s);
        return (s == ST_REL_HEAD) || (s == ST_REL_TAIL);
    endfunction

endpackage

// File: rtl/csc_wait_timer.sv
module csc_wait_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == limit);

endmodule

// File: rtl/csc_stray_cnt.sv
module csc_stray_cnt #(
    parameter int STRAY_W   = 8,
    parameter bit STRAY_SAT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc,
    output logic [STRAY_W-1:0] count
);

    logic [STRAY_W-1:0] cnt_q;

    generate
        if (STRAY_SAT) begin : g_sat
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (inc && (cnt_q != {STRAY_W{1'b1}})) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else begin : g_wrap
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (inc) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

    assign count = cnt_q;

endmodule

// File: rtl/csc_flit_gen.sv
module csc_flit_gen
    import csc_pkg::*;
#(
    parameter int FLIT_W = 16,
    parameter int DEST_W = 6
) (
    input  csc_state_e         state,
    input  logic [DEST_W-1:0]  dest,
    output logic               flit_valid,
    output logic [FLIT_W-1:0]  flit_data
);

    localparam int PAD_W = FLIT_W - 4 - DEST_W;

    flit_kind_e         kind;
    msg_type_e          mtype;
    logic [DEST_W-1:0]  dest_field;

    always_comb begin
        flit_valid = offers_flit(state);
        kind       = is_head_state(state) ? FK_HEAD : FK_TAIL;
        mtype      = is_release_state(state) ? MSG_RELEASE : MSG_RESERVE;
        dest_field = is_head_state(state) ? dest : '0;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign flit_data = {kind, mtype, {PAD_W{1'b0}}, dest_field};
        end else begin : g_nopad
            assign flit_data = {kind, mtype, dest_field};
        end
    endgenerate

endmodule

// File: rtl/csc_seq.sv
module csc_seq
    import csc_pkg::*;
#(
    parameter int DEST_W = 6,
    parameter int LEN_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [DEST_W-1:0]  req_dest,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               flit_ready,
    input  logic               ack_pulse,
    input  logic               expired,
    input  logic               ch_ready,
    output csc_state_e         state,
    output logic [DEST_W-1:0]  dest_q,
    output logic               req_ready,
    output logic               ch_valid,
    output logic               done,
    output logic               error
);

    csc_state_e        state_q, state_d;
    logic [LEN_W-1:0]  remain_q;
    logic              timed_out_q;
    logic              done_q, err_q;
    logic              tail_taken;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:       if (req_valid)  state_d = ST_RSV_HEAD;
            ST_RSV_HEAD:   if (flit_ready) state_d = ST_RSV_TAIL;
            ST_RSV_TAIL:   if (flit_ready) state_d = ST_WAIT_GRANT;
            ST_WAIT_GRANT: begin
                if (ack_pulse) begin
                    state_d = (remain_q == '0) ? ST_REL_HEAD : ST_STREAM;
                end else if (expired) begin
                    state_d = ST_REL_HEAD;
                end
            end
            ST_STREAM:     if (ch_ready && (remain_q == LEN_W'(1))) state_d = ST_REL_HEAD;
            ST_REL_HEAD:   if (flit_ready) state_d = ST_REL_TAIL;
            ST_REL_TAIL:   if (flit_ready) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign tail_taken = (state_q == ST_REL_TAIL) && flit_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            dest_q      <= '0;
            remain_q    <= '0;
            timed_out_q <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= tail_taken && !timed_out_q;
            err_q   <= tail_taken && timed_out_q;
            if ((state_q == ST_IDLE) && req_valid) begin
                dest_q      <= req_dest;
                remain_q    <= req_len;
                timed_out_q <= 1'b0;
            end
            if ((state_q == ST_STREAM) && ch_ready) begin
                remain_q <= remain_q - 1'b1;
            end
            if ((state_q == ST_WAIT_GRANT) && !ack_pulse && expired) begin
                timed_out_q <= 1'b1;
            end
        end
    end

    assign state     = state_q;
    assign req_ready = (state_q == ST_IDLE);
    assign ch_valid  = (state_q == ST_STREAM);
    assign done      = done_q;
    assign error     = err_q;

endmodule

// File: rtl/circuit_setup_ctrl.sv
module circuit_setup_ctrl
    import csc_pkg::*;
#(
    parameter int DEST_W    = 6,
    parameter int LEN_W     = 8,
    parameter int TMO_W     = 8,
    parameter int FLIT_W    = 16,
    parameter int DATA_W    = 32,
    parameter int STRAY_W   = 8,
    parameter bit STRAY_SAT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [DEST_W-1:0]  req_dest,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [TMO_W-1:0]   timeout_cycles,
    output logic               flit_valid,
    input  logic               flit_ready,
    output logic [FLIT_W-1:0]  flit_data,
    input  logic               ack_pulse,
    output logic               ch_valid,
    input  logic               ch_ready,
    output logic [DATA_W-1:0]  ch_data,
    input  logic [DATA_W-1:0]  pay_word,
    output logic               pay_pop,
    output logic               done,
    output logic               error,
    output logic [STRAY_W-1:0] stray_count
);

    csc_state_e        state;
    logic [DEST_W-1:0] dest_q;
    logic              expired;
    logic              stray_inc;

    csc_seq #(.DEST_W(DEST_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_dest   (req_dest),
        .req_len    (req_len),
        .flit_ready (flit_ready),
        .ack_pulse  (ack_pulse),
        .expired    (expired),
        .ch_ready   (ch_ready),
        .state      (state),
        .dest_q     (dest_q),
        .req_ready  (req_ready),
        .ch_valid   (ch_valid),
        .done       (done),
        .error      (error)
    );

    csc_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT_GRANT),
        .limit   (timeout_cycles),
        .expired (expired)
    );

    csc_flit_gen #(.FLIT_W(FLIT_W), .DEST_W(DEST_W)) u_flit (
        .state      (state),
        .dest       (dest_q),
        .flit_valid (flit_valid),
        .flit_data  (flit_data)
    );

    assign stray_inc = ack_pulse && (state != ST_WAIT_GRANT);

    csc_stray_cnt #(.STRAY_W(STRAY_W), .STRAY_SAT(STRAY_SAT)) u_stray (
        .clk   (clk),
        .rst   (rst),
        .inc   (stray_inc),
        .count (stray_count)
    );

    assign ch_data = pay_word;
    assign pay_pop = ch_valid && ch_ready;

endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
    parameter int FLIT_W  = 16,
    parameter int LEN_W   = 8,
    parameter int STRAY_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [LEN_W-1:0]   req_len,
    input logic               flit_valid,
    input logic               flit_ready,
    input logic [FLIT_W-1:0]  flit_data,
    input logic               ack_pulse,
    input logic               ch_valid,
    input logic               ch_ready,
    input logic               done,
    input logic               error,
    input logic [STRAY_W-1:0] stray_count
);

    localparam logic [FLIT_W-1:0] RSV_TAIL = {2'b10, 2'b00, {(FLIT_W-4){1'b0}}};
    localparam logic [FLIT_W-1:0] REL_TAIL = {2'b10, 2'b01, {(FLIT_W-4){1'b0}}};

    logic             taken, rsv_tail_hs, rel_tail_hs;
    logic             armed, granted;
    logic [LEN_W:0]   words_q;
    logic [LEN_W-1:0] len_q;

    assign taken       = req_valid && req_ready;
    assign rsv_tail_hs = flit_valid && flit_ready && (flit_data == RSV_TAIL);
    assign rel_tail_hs = flit_valid && flit_ready && (flit_data == REL_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            granted <= 1'b0;
            words_q <= '0;
            len_q   <= '0;
        end else begin
            if (taken) begin
                len_q   <= req_len;
                words_q <= '0;
                granted <= 1'b0;
            end else if (ch_valid && ch_ready) begin
                words_q <= words_q + 1'b1;
            end
            if (rsv_tail_hs) begin
                armed <= 1'b1;
            end else if (armed && ack_pulse) begin
                armed   <= 1'b0;
                granted <= 1'b1;
            end
            if (rel_tail_hs) begin
                armed   <= 1'b0;
                granted <= 1'b0;
            end
        end
    end

    assert_flit_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data)));

    assert_no_early_payload_R4: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> granted);

    assert_word_count_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (words_q == {1'b0, len_q}));

    assert_done_after_tail_R7: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> $past(rel_tail_hs));

    assert_error_no_payload_R8: assert property (@(posedge clk) disable iff (rst)
        error |-> (!done && (words_q == '0)));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (flit_valid || ch_valid) |-> !req_ready);

    assert_stray_inc_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_pulse && req_ready && (stray_count != {STRAY_W{1'b1}}))
        |=> (stray_count == $past(stray_count) + 1'b1));

endmodule

bind circuit_setup_ctrl csc_checker #(
    .FLIT_W  (FLIT_W),
    .LEN_W   (LEN_W),
    .STRAY_W (STRAY_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_len     (req_len),
    .flit_valid  (flit_valid),
    .flit_ready  (flit_ready),
    .flit_data   (flit_data),
    .ack_pulse   (ack_pulse),
    .ch_valid    (ch_valid),
    .ch_ready    (ch_ready),
    .done        (done),
    .error       (error),
    .stray_count (stray_count)
);

// File: tb/circuit_setup_ctrl_tb.sv
module circuit_setup_ctrl_tb;

    localparam int DEST_W  = 6;
    localparam int LEN_W   = 8;
    localparam int TMO_W   = 8;
    localparam int FLIT_W  = 16;
    localparam int DATA_W  = 32;
    localparam int STRAY_W = 8;
    localparam logic [DATA_W-1:0] BASE = 32'hA5C0_0000;

    typedef struct packed {
        logic [5:0] dest;
        logic [7:0] len;
        logic [7:0] delay;
        logic [7:0] tmo;
        logic       give;
        logic [1:0] stall;
        logic       extra;
        logic       hold;
    } vec_t;

    // dest, len, grant delay, timeout, grant given, head stall, extra stray, hold request
    localparam vec_t VECS [8] = '{
        '{6'd5,  8'd4, 8'd2, 8'd10, 1'b1, 2'd0, 1'b0, 1'b0},
        '{6'd17, 8'd1, 8'd0, 8'd3,  1'b1, 2'd2, 1'b0, 1'b0},
        '{6'd42, 8'd0, 8'd1, 8'd5,  1'b1, 2'd1, 1'b0, 1'b0},
        '{6'd9,  8'd6, 8'd7, 8'd7,  1'b1, 2'd0, 1'b1, 1'b0},
        '{6'd33, 8'd3, 8'd0, 8'd4,  1'b0, 2'd1, 1'b0, 1'b0},
        '{6'd63, 8'd5, 8'd3, 8'd2,  1'b1, 2'd0, 1'b0, 1'b0},
        '{6'd1,  8'd8, 8'd0, 8'd1,  1'b1, 2'd0, 1'b0, 1'b1},
        '{6'd20, 8'd2, 8'd0, 8'd0,  1'b0, 2'd0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst;
    logic               req_valid, req_ready;
    logic [DEST_W-1:0]  req_dest;
    logic [LEN_W-1:0]   req_len;
    logic [TMO_W-1:0]   timeout_cycles;
    logic               flit_valid, flit_ready;
    logic [FLIT_W-1:0]  flit_data;
    logic               ack_pulse;
    logic               ch_valid, ch_ready;
    logic [DATA_W-1:0]  ch_data, pay_word;
    logic               pay_pop, done, error;
    logic [STRAY_W-1:0] stray_count;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_stray = 0;

    circuit_setup_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .req_len(req_len),
        .timeout_cycles(timeout_cycles),
        .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data),
        .ack_pulse(ack_pulse),
        .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data),
        .pay_word(pay_word), .pay_pop(pay_pop),
        .done(done), .error(error), .stray_count(stray_count)
    );

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FLIT_W-1:0] mk_head(input logic [1:0] t, input logic [5:0] d);
        return {2'b01, t, 6'b0, d};
    endfunction

    function automatic logic [FLIT_W-1:0] mk_tail(input logic [1:0] t);
        return {2'b10, t, 12'b0};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Entered and left just after a falling edge.
    task automatic get_flit(input logic [FLIT_W-1:0] exp, input int stall, input string req);
        for (int s = 0; s < stall; s++) begin
            flit_ready = 1'b0;
            #1;
            check_eq("R3", "stalled flit valid", flit_valid, 1);
            check_eq("R3", "stalled flit data", flit_data, exp);
            check_eq("R9", "req_ready while busy", req_ready, 0);
            @(negedge clk);
        end
        flit_ready = 1'b1;
        #1;
        for (int g = 0; g < 50 && !flit_valid; g++) begin
            @(negedge clk);
            #1;
        end
        check_eq(req, "flit valid", flit_valid, 1);
        check_eq(req, "flit data", flit_data, exp);
        @(negedge clk);
        flit_ready = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        bit exp_err;
        int exp_words;
        int words;
        int i;
        exp_err   = !v.give || (v.delay > v.tmo);
        exp_words = exp_err ? 0 : int'(v.len);
        $display("vector %0d: dest %0d len %0d", idx, v.dest, v.len);

        timeout_cycles = v.tmo;
        req_dest  = v.dest;
        req_len   = v.len;
        req_valid = 1'b1;
        #1;
        check_eq("R9", "req_ready when idle", req_ready, 1);
        @(negedge clk);
        if (v.hold) begin
            req_dest = ~v.dest;
            req_len  = 8'd99;
        end else begin
            req_valid = 1'b0;
        end

        get_flit(mk_head(2'b00, v.dest), int'(v.stall), "R2");
        get_flit(mk_tail(2'b00), 0, "R2");

        words = 0;
        i = 0;
        forever begin
            ack_pulse = (v.give && (i == int'(v.delay))) || (v.extra && (i == int'(v.delay) + 2));
            ch_ready  = (i % 3) != 2;
            pay_word  = BASE + DATA_W'(words);
            #1;
            if (flit_valid || i > 400) break;
            if (ch_valid) begin
                check_eq("R4", "payload only after grant", v.give && (i > int'(v.delay)), 1);
            end
            if (ch_valid && ch_ready) begin
                check_eq("R5", "channel word", ch_data, BASE + DATA_W'(words));
                check_eq("R5", "pay_pop", pay_pop, 1);
                words++;
            end
            @(negedge clk);
            i++;
        end
        if (ack_pulse) @(negedge clk);
        ack_pulse = 1'b0;
        ch_ready  = 1'b0;
        req_valid = 1'b0;
        exp_stray += int'(v.extra) + ((v.give && (int'(v.delay) == int'(v.tmo) + 1)) ? 1 : 0);

        check_eq(exp_err ? "R8" : "R5", "words sent", words, exp_words);
        get_flit(mk_head(2'b01, v.dest), 1, "R6");
        get_flit(mk_tail(2'b01), 0, "R6");
        #1;
        check_eq("R7", "done after release tail", done, !exp_err);
        check_eq("R8", "error after release tail", error, exp_err);
        @(negedge clk);
        #1;
        check_eq("R7", "done one cycle", done, 0);
        check_eq("R8", "error one cycle", error, 0);
        check_eq("R10", "stray count", stray_count, exp_stray);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_dest = '0;
        req_len = '0;
        timeout_cycles = '0;
        flit_ready = 1'b0;
        ack_pulse = 1'b0;
        ch_ready = 1'b0;
        pay_word = '0;
        repeat (3) @(negedge clk);
        #1;
        check_eq("R1", "req_ready in reset", req_ready, 1);
        check_eq("R1", "flit_valid in reset", flit_valid, 0);
        check_eq("R1", "ch_valid in reset", ch_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check_eq("R1", "req_ready after reset", req_ready, 1);
        check_eq("R1", "flit_valid after reset", flit_valid, 0);
        check_eq("R1", "ch_valid after reset", ch_valid, 0);
        check_eq("R1", "pay_pop after reset", pay_pop, 0);
        check_eq("R1", "done/error after reset", {done, error}, 0);
        check_eq("R1", "stray after reset", stray_count, 0);

        // stray grants while idle
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            ack_pulse = 1'b1;
            @(negedge clk);
            ack_pulse = 1'b0;
        end
        exp_stray = 2;
        #1;
        check_eq("R10", "idle stray count", stray_count, exp_stray);
        check_eq("R10", "idle stray no flit", flit_valid, 0);
        check_eq("R10", "idle stray no done", done, 0);

        for (int n = 0; n < 8; n++) begin
            run_vec(VECS[n], n);
        end

        // saturation of the stray counter
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            ack_pulse = 1'b1;
            @(negedge clk);
            ack_pulse = 1'b0;
        end
        #1;
        check_eq("R10", "stray saturates", stray_count, 255);
        check_eq("R10", "still idle after strays", req_ready, 1);

        summary();
        $finish;
    end

endmodule